// File: doc/BRIEF.md
# Bus Error Monitor with Interrupt Status

This block sits beside an external bus sequencer and watches every access it issues. On each access strobe it looks at the eight region-hit lines from the address decoder and flags an access that hits no region or more than one region. It remembers the regions of the current access. When read data returns from a region with parity checking turned on, it checks one odd parity bit per byte lane. It also takes a timeout pulse from the sequencer for the access in flight.

Errors gather in a sticky status word. The word has one flag per region involved and one bit per error class. An interrupt line stays high while any class bit is set. The first error after a clear loads an address log, plus data and parity logs when the error is a parity error. Software reads the status word with a one-cycle read pulse. The read returns the current value and clears the whole word at the next edge. An error that arrives during the read cycle is kept.

Top module: `buserr_monitor`

## Requirements
- R1: After reset the status word, the interrupt and all three logs are zero.
- R2: An access strobe with no region hit sets status bit 11, adds no region flag, and puts the access address in the address log; the status changes on the edge that samples the strobe.
- R3: An access strobe with two or more region hits sets status bit 12 and sets the region flags (bits 7:0) of every region hit.
- R4: Read data is checked with odd parity: parity bit i together with data byte i (bits 8i+7..8i) must hold an odd count of ones. On a failed lane, when the latched region of the access has parity enabled, status bit 9 and that region's flag are set. The address log receives the access address with its two low bits cleared. The data and parity logs receive the read word and its four parity bits.
- R5: Read data with bad parity from a region whose parity enable is low raises no error.
- R6: A timeout pulse sets status bit 10 and the flags of the regions of the last access, and logs that access's address.
- R7: The interrupt output is high exactly while any of status bits 9 to 12 is set and stays high until a status read clears them.
- R8: A status read pulse returns the current word in that cycle and clears the whole word at the next edge; bit 8 and unused bits always read zero.
- R9: While any error bit is set, later errors add status bits but leave all three logs unchanged.
- R10: An error in the same cycle as a status read is not lost: the read returns the old value, and afterwards the word holds only the new error and the logs hold the new error's information.
- R11: An access that hits exactly one region and raises no parity or timeout error leaves the status at zero.
- R12: When several errors arise in one cycle, the address log takes the parity error's word address first, then the timeout address, then the decode address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe, one cycle per access |
| accAddr | input | 32 | Address of the access |
| regionHit | input | 8 | Decoder hit line per region, valid with accValid |
| parityEn | input | 8 | Per-region parity check enable |
| rdValid | input | 1 | Read data return strobe |
| rdData | input | 32 | Returned read word |
| rdParity | input | 4 | Returned parity, one bit per byte lane |
| timeoutPulse | input | 1 | Timeout indication for the access in flight |
| statusRead | input | 1 | Status read pulse; clears at the next edge |
| status | output | 13 | Status word: region flags 7:0, zero 8, parity 9, timeout 10, no-hit 11, multi-hit 12 |
| irq | output | 1 | Interrupt request |
| logAddr | output | 32 | Logged error address |
| logData | output | 32 | Logged read data of a parity error |
| logParity | output | 4 | Logged parity bits of a parity error |

## Verification
The bench aims at the collision of a status read with a new error. A design that clears after setting would lose the event, and one that keeps the old bits would show stale flags. It checks that a second error leaves the logs untouched, because a design that always captures would overwrite the first failing address. It checks bad parity from a region without parity enabled, which a careless design would report. It also drives a parity error, a timeout and a decode miss in one cycle, where a wrong priority would log the wrong address or an unaligned word address.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
  typedef enum logic [1:0] {
    ADDR_CUR   = 2'd0,
    ADDR_LATCH = 2'd1,
    ADDR_WORD  = 2'd2
  } addrSel_t;

  typedef struct packed {
    logic     latchAcc;
    logic     setParity;
    logic     setTimeout;
    logic     setNoHit;
    logic     setMulti;
    logic     capture;
    logic     captureData;
    logic     clear;
    addrSel_t addrSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/buserr_ctrl.sv
module buserr_ctrl
  import buserr_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [NREG-1:0]  regionHit,
  input  logic [NREG-1:0]  parityEn,
  input  logic             rdValid,
  input  logic [LANES-1:0] laneFault,
  input  logic             timeoutPulse,
  input  logic             statusRead,
  input  logic             anyErr,
  output ctrlStrobe_t      strobe,
  output logic [NREG-1:0]  regionSet
);
  localparam int CW = $clog2(NREG + 1);

  logic [NREG-1:0] hitQ;
  logic [CW-1:0]   hitCount;
  logic            noHit, multiHit, parErr, newErr;

  always_ff @(posedge clk) begin
    if (!rstN) hitQ <= '0;
    else if (accValid) hitQ <= regionHit;
  end

  always_comb begin
    hitCount = '0;
    for (int i = 0; i < NREG; i++) hitCount = hitCount + CW'(regionHit[i]);
  end

  always_comb begin
    noHit    = accValid && (hitCount == '0);
    multiHit = accValid && (hitCount > CW'(1));
    parErr   = rdValid && (|laneFault) && (|(hitQ & parityEn));
    newErr   = noHit || multiHit || parErr || timeoutPulse;

    regionSet = '0;
    if (parErr)       regionSet = regionSet | (hitQ & parityEn);
    if (timeoutPulse) regionSet = regionSet | hitQ;
    if (multiHit)     regionSet = regionSet | regionHit;

    strobe.latchAcc    = accValid;
    strobe.setParity   = parErr;
    strobe.setTimeout  = timeoutPulse;
    strobe.setNoHit    = noHit;
    strobe.setMulti    = multiHit;
    strobe.capture     = newErr && (statusRead || !anyErr);
    strobe.captureData = newErr && parErr && (statusRead || !anyErr);
    strobe.clear       = statusRead;
    if (parErr)            strobe.addrSel = ADDR_WORD;
    else if (timeoutPulse) strobe.addrSel = ADDR_LATCH;
    else                   strobe.addrSel = ADDR_CUR;
  end
endmodule

// File: rtl/buserr_data.sv
module buserr_data
  import buserr_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LANES = DW / 8,
  parameter int SW    = NREG + 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [NREG-1:0]  regionSet,
  input  logic [AW-1:0]    accAddr,
  input  logic [DW-1:0]    rdData,
  input  logic [LANES-1:0] rdParity,
  output logic [LANES-1:0] laneFault,
  output logic             anyErr,
  output logic [SW-1:0]    status,
  output logic             irq,
  output logic [AW-1:0]    logAddr,
  output logic [DW-1:0]    logData,
  output logic [LANES-1:0] logParity
);
  localparam int OFFW = $clog2(LANES);

  logic [AW-1:0]   addrQ;
  logic [NREG-1:0] flagsQ;
  logic [3:0]      errQ;
  logic [3:0]      errNew;
  logic [AW-1:0]   addrPick;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneFault[g] = ~(^{rdData[8*g +: 8], rdParity[g]});
  end

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else if (strobe.latchAcc) addrQ <= accAddr;
  end

  assign errNew = {strobe.setMulti, strobe.setNoHit, strobe.setTimeout, strobe.setParity};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
      errQ   <= '0;
    end else if (strobe.clear) begin
      flagsQ <= regionSet;
      errQ   <= errNew;
    end else begin
      flagsQ <= flagsQ | regionSet;
      errQ   <= errQ | errNew;
    end
  end

  always_comb begin
    unique case (strobe.addrSel)
      ADDR_WORD:  addrPick = {addrQ[AW-1:OFFW], {OFFW{1'b0}}};
      ADDR_LATCH: addrPick = addrQ;
      default:    addrPick = accAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      logAddr   <= '0;
      logData   <= '0;
      logParity <= '0;
    end else begin
      if (strobe.capture) logAddr <= addrPick;
      if (strobe.captureData) begin
        logData   <= rdData;
        logParity <= rdParity;
      end
    end
  end

  assign anyErr = |errQ;
  assign irq    = anyErr;
  assign status = {errQ, 1'b0, flagsQ};
endmodule

// File: rtl/buserr_monitor.sv
module buserr_monitor
  import buserr_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LANES = DW / 8,
  parameter int SW    = NREG + 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic [AW-1:0]    accAddr,
  input  logic [NREG-1:0]  regionHit,
  input  logic [NREG-1:0]  parityEn,
  input  logic             rdValid,
  input  logic [DW-1:0]    rdData,
  input  logic [LANES-1:0] rdParity,
  input  logic             timeoutPulse,
  input  logic             statusRead,
  output logic [SW-1:0]    status,
  output logic             irq,
  output logic [AW-1:0]    logAddr,
  output logic [DW-1:0]    logData,
  output logic [LANES-1:0] logParity
);
  ctrlStrobe_t      strobe;
  logic [NREG-1:0]  regionSet;
  logic [LANES-1:0] laneFault;
  logic             anyErr;

  buserr_ctrl #(.NREG(NREG), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .regionHit(regionHit),
    .parityEn(parityEn), .rdValid(rdValid), .laneFault(laneFault),
    .timeoutPulse(timeoutPulse), .statusRead(statusRead), .anyErr(anyErr),
    .strobe(strobe), .regionSet(regionSet)
  );

  buserr_data #(.NREG(NREG), .AW(AW), .DW(DW), .LANES(LANES), .SW(SW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regionSet(regionSet),
    .accAddr(accAddr), .rdData(rdData), .rdParity(rdParity),
    .laneFault(laneFault), .anyErr(anyErr), .status(status), .irq(irq),
    .logAddr(logAddr), .logData(logData), .logParity(logParity)
  );
endmodule

// File: rtl/buserr_monitor_chk.sv
module buserr_monitor_chk #(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int SW   = NREG + 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            accValid,
  input logic [NREG-1:0] regionHit,
  input logic            rdValid,
  input logic            timeoutPulse,
  input logic            statusRead,
  input logic [SW-1:0]   status,
  input logic            irq,
  input logic [AW-1:0]   logAddr
);
  // R2
  nohit_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid && (regionHit == '0) |=> status[NREG+3]);

  // R3
  multi_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid && ($countones(regionHit) > 1) |=> status[NREG+4]);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !statusRead |=> irq);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusRead && !accValid && !rdValid && !timeoutPulse |=> (status == '0) && !irq);

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[NREG] == 1'b0);

  // R9
  log_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !statusRead |=> $stable(logAddr));
endmodule

bind buserr_monitor buserr_monitor_chk #(.NREG(NREG), .AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .regionHit(regionHit),
  .rdValid(rdValid), .timeoutPulse(timeoutPulse), .statusRead(statusRead),
  .status(status), .irq(irq), .logAddr(logAddr)
);

// File: tb/tb_buserr_monitor.sv
module tb_buserr_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [7:0]  regionHit = '0;
  logic [7:0]  parityEn = '0;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;
  logic [3:0]  rdParity = '0;
  logic        timeoutPulse = 1'b0;
  logic        statusRead = 1'b0;
  logic [12:0] status;
  logic        irq;
  logic [31:0] logAddr;
  logic [31:0] logData;
  logic [3:0]  logParity;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  buserr_monitor dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .regionHit(regionHit), .parityEn(parityEn), .rdValid(rdValid),
    .rdData(rdData), .rdParity(rdParity), .timeoutPulse(timeoutPulse),
    .statusRead(statusRead), .status(status), .irq(irq), .logAddr(logAddr),
    .logData(logData), .logParity(logParity)
  );

  localparam logic [12:0] B_PAR = 13'h0200;
  localparam logic [12:0] B_TMO = 13'h0400;
  localparam logic [12:0] B_NOHIT = 13'h0800;
  localparam logic [12:0] B_MULTI = 13'h1000;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] oddPar(logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ~(^d[8*i +: 8]);
    return p;
  endfunction

  task automatic doAccess(logic [31:0] a, logic [7:0] h);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; regionHit = h;
    @(negedge clk);
    accValid = 1'b0; regionHit = '0;
  endtask

  task automatic doRead(logic [31:0] d, logic [3:0] p);
    @(negedge clk);
    rdValid = 1'b1; rdData = d; rdParity = p;
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic clearStatus();
    @(negedge clk);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 status", 64'(status), 64'h0);
    check("R1 irq", 64'(irq), 64'h0);
    check("R1 logs", {logAddr, logData}, 64'h0);
    check("R1 logParity", 64'(logParity), 64'h0);
  endtask

  task automatic t_clean();
    parityEn = 8'h00;
    doAccess(32'h0000_2000, 8'h04);
    check("R11 single hit", 64'(status), 64'h0);
    doRead(32'h1234_5678, ~oddPar(32'h1234_5678));
    check("R5 parity disabled", 64'(status), 64'h0);
    check("R5 irq", 64'(irq), 64'h0);
    parityEn = 8'h04;
    doRead(32'h1234_5678, oddPar(32'h1234_5678));
    check("R4 good parity", 64'(status), 64'h0);
    parityEn = 8'h00;
  endtask

  task automatic t_miss();
    doAccess(32'h0000_1234, 8'h00);
    check("R2 status", 64'(status), 64'(B_NOHIT));
    check("R2 logAddr", 64'(logAddr), 64'h1234);
    check("R7 irq set", 64'(irq), 64'h1);
    repeat (3) @(negedge clk);
    check("R7 irq held", 64'(irq), 64'h1);
    @(negedge clk);
    statusRead = 1'b1;
    #1;
    check("R8 read value", 64'(status), 64'(B_NOHIT));
    @(negedge clk);
    statusRead = 1'b0;
    check("R8 cleared", 64'(status), 64'h0);
    check("R7 irq cleared", 64'(irq), 64'h0);
  endtask

  task automatic t_multi();
    doAccess(32'h0000_ABCD, 8'h41);
    check("R3 status", 64'(status), 64'(B_MULTI | 13'h041));
    check("R3 logAddr", 64'(logAddr), 64'hABCD);
    check("R8 reserved bit", 64'(status[8]), 64'h0);
    clearStatus();
  endtask

  task automatic t_parity();
    logic [31:0] d = 32'hDEAD_BEEF;
    logic [3:0]  p = oddPar(32'hDEAD_BEEF) ^ 4'b0100;
    parityEn = 8'h20;
    doAccess(32'h0000_1007, 8'h20);
    check("R4 no error yet", 64'(status), 64'h0);
    doRead(d, p);
    check("R4 status", 64'(status), 64'(B_PAR | 13'h020));
    check("R4 word address", 64'(logAddr), 64'h1004);
    check("R4 data log", 64'(logData), 64'(d));
    check("R4 parity log", 64'(logParity), 64'(p));
    parityEn = 8'h00;
    clearStatus();
  endtask

  task automatic t_timeoutHold();
    doAccess(32'h0000_3000, 8'h02);
    @(negedge clk);
    timeoutPulse = 1'b1;
    @(negedge clk);
    timeoutPulse = 1'b0;
    check("R6 status", 64'(status), 64'(B_TMO | 13'h002));
    check("R6 logAddr", 64'(logAddr), 64'h3000);
    doAccess(32'h0000_5555, 8'h00);
    check("R9 status accumulates", 64'(status), 64'(B_TMO | B_NOHIT | 13'h002));
    check("R9 logAddr held", 64'(logAddr), 64'h3000);
    clearStatus();
  endtask

  task automatic t_readCollide();
    doAccess(32'h0000_0100, 8'h00);
    @(negedge clk);
    statusRead = 1'b1; accValid = 1'b1; accAddr = 32'h0000_0200; regionHit = 8'h03;
    #1;
    check("R10 old value", 64'(status), 64'(B_NOHIT));
    @(negedge clk);
    statusRead = 1'b0; accValid = 1'b0; regionHit = '0;
    check("R10 new error kept", 64'(status), 64'(B_MULTI | 13'h003));
    check("R10 new log", 64'(logAddr), 64'h200);
    clearStatus();
  endtask

  task automatic t_priority();
    parityEn = 8'h10;
    doAccess(32'h0000_400B, 8'h10);
    @(negedge clk);
    rdValid = 1'b1; rdData = 32'h0F0F_0F0F; rdParity = ~oddPar(32'h0F0F_0F0F);
    timeoutPulse = 1'b1;
    accValid = 1'b1; accAddr = 32'h0000_9000; regionHit = 8'h00;
    @(negedge clk);
    rdValid = 1'b0; timeoutPulse = 1'b0; accValid = 1'b0;
    check("R12 status", 64'(status), 64'(B_PAR | B_TMO | B_NOHIT | 13'h010));
    check("R12 logAddr parity first", 64'(logAddr), 64'h4008);
    parityEn = 8'h00;
    clearStatus();
    check("R8 cleared after priority", 64'(status), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_miss();
    t_multi();
    t_parity();
    t_timeoutHold();
    t_readCollide();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule